// File: doc/BRIEF.md
# GPIO Port With Blink

This block is a general-purpose I/O port of up to 32 lines with a small word-wide register bus. Software sets each line's direction, the level it drives when it is an output, an inversion applied to what it reads when it is an input, and an enable that makes an output blink. The port drives an output-enable vector and an output-level vector to the pads. It samples the pad inputs through a two-stage synchronizer.

Every blinking line follows one shared square wave. A free-running prescaler toggles this wave every `BLINK_DIV` clock cycles. A blinking line drives the wave ORed with its static output bit. A combined per-line view register returns, for each line, the polarity-adjusted input when the line is an input and the output bit when it is an output.

Reads are registered. Read data appears on the bus one cycle after the request and holds until the next read. Writes take effect at the clock edge that accepts them.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset every direction bit is 1 (input) and the output-level, polarity and blink registers read 0. `pad_oe_o` and `pad_out_o` are all 0.
- R2: Word offset 0x04 (direction) sets, per line, 1 = input with the driver off and 0 = output. `pad_oe_o` is the inverse of this register and follows a write from the next cycle on.
- R3: Word offset 0x00 (output level) sets the level on `pad_out_o`. A line whose blink bit is 0 drives its bit unchanged from the cycle after the write.
- R4: Word offset 0x10 (input data, read-only) returns the pad input after two synchronizer flops, XORed per line with word offset 0x0C (polarity). A read issued in the cycle a pad changes still returns the old level. A read issued two cycles later returns the new one.
- R5: Word offset 0x14 (line view, read-only) returns, per line, the input-data bit when the direction bit is 1 and the output-level bit when it is 0.
- R6: Word offset 0x08 (blink enable) makes a line drive the shared blink phase ORed with its output bit. The phase starts at 0 after reset and toggles once every `BLINK_DIV` cycles. With the blink bit at 0 the line drives its output bit only.
- R7: Writable registers read back the last written value. Writes to offsets 0x10 and 0x14 change no register. Reads of unmapped offsets return 0.
- R8: Read data is registered. It is valid the cycle after a read request and stays stable while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request valid for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe_o | output | NUM_PINS | Per-line output driver enable |
| pad_out_o | output | NUM_PINS | Per-line driven level |

## Verification
Read data is due one edge after the request. The bench therefore queues each expected word when it issues a read, and a monitor compares the word just after the following rising edge. Pad outputs are due the cycle after the write that sets them and are sampled after that edge. The input path needs two edges of synchronizer delay. A read issued together with a pad change must return the old value, and a read issued two cycles later the new one. Blink behaviour is checked by counting transitions over exactly four prescaler periods, and by requiring all blinking lines to agree on every sample.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [2:0] {
    RI_OUT   = 3'd0,
    RI_DIR   = 3'd1,
    RI_BLINK = 3'd2,
    RI_POL   = 3'd3,
    RI_DIN   = 3'd4,
    RI_VIEW  = 3'd5,
    RI_NONE  = 3'd7
  } reg_idx_e;

  function automatic reg_idx_e decode_word(input logic [2:0] w, input logic hi_nz);
    reg_idx_e r;
    if (hi_nz) r = RI_NONE;
    else begin
      case (w)
        3'd0:    r = RI_OUT;
        3'd1:    r = RI_DIR;
        3'd2:    r = RI_BLINK;
        3'd3:    r = RI_POL;
        3'd4:    r = RI_DIN;
        3'd5:    r = RI_VIEW;
        default: r = RI_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  input  logic [NUM_PINS-1:0] din_i,
  input  logic [NUM_PINS-1:0] view_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] blink_o,
  output logic [NUM_PINS-1:0] pol_o
);
  localparam int unsigned HI_W = (ADDR_W > 5) ? ADDR_W - 5 : 1;

  logic [NUM_PINS-1:0] out_q, dir_q, blink_q, pol_q;
  logic [REG_W-1:0]    rdata_q, rdata_d;
  logic                hi_nz;
  reg_idx_e            sel;

  if (ADDR_W > 5) begin : g_hi
    logic [HI_W-1:0] hi;
    assign hi    = bus_addr_i[ADDR_W-1:5];
    assign hi_nz = |hi;
  end else begin : g_nohi
    assign hi_nz = 1'b0;
  end

  assign sel = decode_word(bus_addr_i[4:2], hi_nz);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
    end else if (bus_req_i && bus_we_i) begin
      case (sel)
        RI_OUT:   out_q   <= bus_wdata_i[NUM_PINS-1:0];
        RI_DIR:   dir_q   <= bus_wdata_i[NUM_PINS-1:0];
        RI_BLINK: blink_q <= bus_wdata_i[NUM_PINS-1:0];
        RI_POL:   pol_q   <= bus_wdata_i[NUM_PINS-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RI_OUT:   rdata_d = REG_W'(out_q);
      RI_DIR:   rdata_d = REG_W'(dir_q);
      RI_BLINK: rdata_d = REG_W'(blink_q);
      RI_POL:   rdata_d = REG_W'(pol_q);
      RI_DIN:   rdata_d = REG_W'(din_i);
      RI_VIEW:  rdata_d = REG_W'(view_i);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (bus_req_i && !bus_we_i) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
  assign out_o       = out_q;
  assign dir_o       = dir_q;
  assign blink_o     = blink_q;
  assign pol_o       = pol_q;
endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
  import gpio_blink_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BLINK_DIV = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o
);
  logic [NUM_PINS-1:0] pad_sync, din, view;
  logic [NUM_PINS-1:0] out_r, dir_r, blink_en, pol_r;
  logic                phase;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  gpio_blink_timer #(.DIV(BLINK_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .din_i      (din),
    .view_i     (view),
    .out_o      (out_r),
    .dir_o      (dir_r),
    .blink_o    (blink_en),
    .pol_o      (pol_r)
  );

  assign din = pad_sync ^ pol_r;

  // per-line readback: input -> adjusted data, output -> driven register
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign view[p]      = dir_r[p] ? din[p] : out_r[p];
    assign pad_oe_o[p]  = ~dir_r[p];
    assign pad_out_o[p] = out_r[p] | (blink_en[p] & phase);
  end
endmodule

// File: rtl/gpio_blink_port_chk.sv
module gpio_blink_port_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [31:0]         bus_wdata_i,
  input logic [31:0]         bus_rdata_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] out_r,
  input logic [NUM_PINS-1:0] blink_en
);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(4);

  logic wr_dir, wr_out, rd;
  logic [NUM_PINS-1:0] blink_lo;
  assign wr_dir   = bus_req_i && bus_we_i && (bus_addr_i == A_DIR);
  assign wr_out   = bus_req_i && bus_we_i && (bus_addr_i == A_OUT);
  assign rd       = bus_req_i && !bus_we_i;
  assign blink_lo = blink_en & ~out_r;

  // R2
  dir_to_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pad_oe_o == ~$past(bus_wdata_i[NUM_PINS-1:0]));

  // R3
  out_to_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_out && blink_en == '0) |=> pad_out_o == $past(bus_wdata_i[NUM_PINS-1:0]));

  // R6
  shared_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o & blink_lo) == '0) || ((pad_out_o & blink_lo) == blink_lo));

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata_o));
endmodule

bind gpio_blink_port gpio_blink_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .pad_oe_o   (pad_oe_o),
  .pad_out_o  (pad_out_o),
  .out_r      (out_r),
  .blink_en   (blink_en)
);

// File: tb/tb_gpio_blink_port.sv
`timescale 1ns/1ps
module tb_gpio_blink_port;
  localparam int unsigned N   = 32;
  localparam int unsigned AW  = 8;
  localparam int unsigned DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pad_in = '0, pad_oe, pad_out;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_blink_port #(.NUM_PINS(N), .ADDR_W(AW), .BLINK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read data due just after the edge that accepted the request
  always @(posedge clk) begin
    if (rst_n && req && !we) begin
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] dir_v, out_v, pol_v, pin_v, din_v, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);
    rd(8'h04, 32'hFFFF_FFFF, "R1 dir");
    rd(8'h00, 32'h0, "R1 outreg");
    rd(8'h08, 32'h0, "R1 blink");
    rd(8'h0C, 32'h0, "R1 pol");

    // R2 direction
    dir_v = 32'hFFFF_0000;
    wr(8'h04, dir_v);
    check("R2 oe", pad_oe, ~dir_v);
    rd(8'h04, dir_v, "R7 dir readback");

    // R3 output level
    out_v = 32'h1234_A5C3;
    wr(8'h00, out_v);
    check("R3 pad_out", pad_out, out_v);
    rd(8'h00, out_v, "R7 out readback");

    // R4 input with and without polarity
    pin_v = 32'hDEAD_BEEF;
    @(negedge clk); pad_in = pin_v;
    repeat (3) @(negedge clk);
    rd(8'h10, pin_v, "R4 din");
    pol_v = 32'h0F0F_0F0F;
    wr(8'h0C, pol_v);
    din_v = pin_v ^ pol_v;
    rd(8'h10, din_v, "R4 din pol");
    // R4 latency: read in change cycle sees old, read two cycles later sees new
    @(negedge clk);
    pad_in = 32'h0; req = 1; we = 0; addr = 8'h10;
    exp_q.push_back(din_v); tag_q.push_back("R4 old");
    @(negedge clk); req = 0;
    rd(8'h10, pol_v, "R4 new");
    din_v = pol_v;

    // R5 line view
    rd(8'h14, (dir_v & din_v) | (~dir_v & out_v), "R5 view");
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    din_v = ~pol_v;
    rd(8'h14, (dir_v & din_v) | (~dir_v & out_v), "R5 view2");

    // R7 read-only and unmapped
    wr(8'h10, 32'hAAAA_5555);
    wr(8'h14, 32'h5555_AAAA);
    rd(8'h0C, pol_v, "R7 pol intact");
    rd(8'h00, out_v, "R7 out intact");
    rd(8'h04, dir_v, "R7 dir intact");
    rd(8'h18, 32'h0, "R7 unmapped");
    rd(8'h40, 32'h0, "R7 high unmapped");

    // R8 hold while idle
    held = rdata;
    repeat (5) @(negedge clk);
    check("R8 hold", rdata, held);

    // R6 blink
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0010);
    wr(8'h08, 32'h0000_00F0);
    rd(8'h08, 32'h0000_00F0, "R7 blink readback");
    begin
      int toggles = 0;
      logic prev;
      @(negedge clk);
      prev = pad_out[5];
      for (int i = 0; i < 4 * DIV; i++) begin
        @(negedge clk);
        if (pad_out[5] != prev) toggles++;
        prev = pad_out[5];
        if (pad_out[4] !== 1'b1 || pad_out[6] !== pad_out[5] || pad_out[7] !== pad_out[5]
            || (pad_out & 32'hFFFF_FF0F) !== 32'h0) begin
          n_bad++;
          $display("FAIL R6 shape actual=%h expected=bit4 high, bits5-7 equal", pad_out);
        end
      end
      n_chk++;
      check("R6 toggles", 32'(toggles), 32'd4);
    end
    wr(8'h08, 32'h0);
    repeat (2 * DIV) @(negedge clk);
    check("R6 off", pad_out, 32'h0000_0010);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule